// File: doc/BRIEF.md
# Accumulator Machine Interrupt Controller

This block holds the flags and sequencing that let a small accumulator computer service one 8-bit input channel and one 8-bit output channel by interrupt. It keeps an input-ready flag, an output-ready flag, an interrupt-enable flag and an interrupt-pending flag. It also holds the input and output character registers. It answers the I/O commands issued by the main control: read a character, write a character, enable or disable interrupts, and skip on either flag.

The main control supplies the current sequence-counter step and the program counter value. When the pending flag is set, the main control runs an interrupt cycle in place of the next instruction fetch. This block then drives three steps. It saves the program counter at memory word 0, reloads the program counter to address 1, disables interrupts and clears the sequence counter. The program counter, memory and accumulator stay outside the block. The block drives only write strobes and data for them.

Top module: `intr_ctl`

## Requirements
- R1: After reset the input flag, output flag, enable flag and pending flag are 0. `intr_cycle`, `mem_we`, `pc_we`, `out_stb` and `out_char` are 0.
- R2: A `dev_in_stb` pulse loads `dev_in_char` and sets the input flag. While the input flag is 1, `cmd_ski` drives `pc_we`=1 and `pc_wdata`=`pc_i`+1 in the same cycle. While the flag is 0, `cmd_ski` leaves `pc_we` at 0.
- R3: `cmd_inp` drives `ac_lo_we`=1 with `ac_lo_wdata` equal to the held input character in the same cycle, and it clears the input flag.
- R4: `dev_out_done` sets the output flag, and `cmd_sko` then skips the same way as in R2. `cmd_out` captures `ac_i[7:0]` into `out_char` and clears the output flag. On the next cycle `out_stb` is 1 for one cycle.
- R5: When `cmd_inp` and `dev_in_stb` fall in the same cycle, the accumulator receives the old character. The new character is then held and the input flag stays 1.
- R6: The pending flag, seen as `intr_cycle`=1, is set one cycle after a cycle in which three things hold: the enable flag is 1, at least one of the two device flags is 1, and `sc_step` is 3 or more.
- R7: While the enable flag is 0, device flag activity never sets the pending flag.
- R8: While `sc_step` is 0, 1 or 2, the pending flag is not set, so a fetch that has started is never interrupted.
- R9: During the interrupt cycle, step 0 writes nothing and latches `pc_i`. Step 1 drives `mem_we`=1 at `mem_addr`=0 with the latched value zero-extended, and it sets `pc_we`=1, `pc_wdata`=0. Step 2 sets `pc_we`=1, `pc_wdata`=`pc_i`+1 and `sc_clr`=1. After step 2 the enable flag and the pending flag are 0.
- R10: `cmd_ion` sets the enable flag and `cmd_iof` clears it. When both are given together, `cmd_iof` wins. The new enable value counts toward R6 from the following cycle.
- R11: When `cmd_out` and `dev_out_done` fall in the same cycle, the output flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_step | input | SCW | Current sequence-counter step |
| pc_i | input | AW | Current program counter |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | AW | Program counter load value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| sc_clr | output | 1 | Sequence counter clear |
| intr_cycle | output | 1 | Pending flag: interrupt cycle replaces the fetch |
| dev_in_stb | input | 1 | Input device delivers a character |
| dev_in_char | input | CW | Character from input device |
| dev_out_done | input | 1 | Output device finished its character |
| out_char | output | CW | Character held for output device |
| out_stb | output | 1 | One-cycle pulse: new output character |
| cmd_ion | input | 1 | Enable interrupts |
| cmd_iof | input | 1 | Disable interrupts |
| cmd_inp | input | 1 | Move input character to accumulator low byte |
| cmd_out | input | 1 | Move accumulator low byte to output |
| cmd_ski | input | 1 | Skip next instruction if input flag set |
| cmd_sko | input | 1 | Skip next instruction if output flag set |
| ac_i | input | DW | Accumulator value |
| ac_lo_we | output | 1 | Accumulator low-byte write strobe |
| ac_lo_wdata | output | CW | Accumulator low-byte write value |

## Verification
Two functions can fall in the same cycle. The first is a character arriving from the input device, and the second is the program's INP command taking the previously held character. The bench makes this happen by loading one character, then pulsing the device strobe with a second character in the same cycle as `cmd_inp`. The check has three parts: the accumulator write must carry the first character, a skip-on-input must still fire afterwards, and a second INP must deliver the second character. The bench also provokes the same kind of collision between OUT and a device-done pulse, and expects the clear to win.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic [1:0] {
        RT_SAVE   = 2'd0,
        RT_WRITE  = 2'd1,
        RT_VECTOR = 2'd2,
        RT_IDLE   = 2'd3
    } irq_step_e;

endpackage

// File: rtl/intr_io.sv
module intr_io #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_in_stb,
    input  logic [CW-1:0] dev_in_char,
    input  logic          dev_out_done,
    input  logic          cmd_inp,
    input  logic          cmd_out,
    input  logic [DW-1:0] ac_i,
    output logic          fgi,
    output logic          fgo,
    output logic          ac_lo_we,
    output logic [CW-1:0] ac_lo_wdata,
    output logic [CW-1:0] out_char,
    output logic          out_stb
);

    typedef struct packed {
        logic          in_rdy;
        logic          out_rdy;
        logic [CW-1:0] in_buf;
        logic [CW-1:0] out_buf;
        logic          out_new;
    } io_state_t;

    io_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.out_new = 1'b0;
        // taking a character clears the flag; a fresh arrival wins
        if (cmd_inp) begin
            s_d.in_rdy = 1'b0;
        end
        if (dev_in_stb) begin
            s_d.in_buf = dev_in_char;
            s_d.in_rdy = 1'b1;
        end
        // device done sets the flag; a new OUT clears it and wins
        if (dev_out_done) begin
            s_d.out_rdy = 1'b1;
        end
        if (cmd_out) begin
            s_d.out_buf = ac_i[CW-1:0];
            s_d.out_rdy = 1'b0;
            s_d.out_new = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fgi         = s_q.in_rdy;
    assign fgo         = s_q.out_rdy;
    assign ac_lo_we    = cmd_inp;
    assign ac_lo_wdata = s_q.in_buf;
    assign out_char    = s_q.out_buf;
    assign out_stb     = s_q.out_new;

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int SCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SCW-1:0] sc_step,
    input  logic [AW-1:0]  pc_i,
    input  logic           fgi,
    input  logic           fgo,
    input  logic           cmd_ion,
    input  logic           cmd_iof,
    input  logic           cmd_ski,
    input  logic           cmd_sko,
    output logic           pc_we,
    output logic [AW-1:0]  pc_wdata,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           sc_clr,
    output logic           ien,
    output logic           pend
);

    localparam logic [SCW-1:0] FETCH_LAST = SCW'(2);
    localparam logic [AW-1:0]  SAVE_ADDR  = '0;

    typedef struct packed {
        logic          ien;
        logic          pend;
        logic [AW-1:0] ar;
        logic [AW-1:0] tr;
    } seq_state_t;

    seq_state_t s_d, s_q;
    irq_step_e  rt;

    always_comb begin
        if (s_q.pend && (sc_step <= FETCH_LAST)) begin
            rt = irq_step_e'(sc_step[1:0]);
        end else begin
            rt = RT_IDLE;
        end
    end

    always_comb begin
        s_d      = s_q;
        pc_we    = 1'b0;
        pc_wdata = pc_i;
        mem_we   = 1'b0;
        sc_clr   = 1'b0;
        if (s_q.pend) begin
            case (rt)
                RT_SAVE: begin
                    s_d.ar = SAVE_ADDR;
                    s_d.tr = pc_i;
                end
                RT_WRITE: begin
                    mem_we   = 1'b1;
                    pc_we    = 1'b1;
                    pc_wdata = '0;
                end
                RT_VECTOR: begin
                    pc_we    = 1'b1;
                    pc_wdata = pc_i + AW'(1);
                    s_d.ien  = 1'b0;
                    s_d.pend = 1'b0;
                    sc_clr   = 1'b1;
                end
                default: ;
            endcase
        end else begin
            if ((sc_step > FETCH_LAST) && s_q.ien && (fgi || fgo)) begin
                s_d.pend = 1'b1;
            end
            if ((cmd_ski && fgi) || (cmd_sko && fgo)) begin
                pc_we    = 1'b1;
                pc_wdata = pc_i + AW'(1);
            end
            if (cmd_ion) begin
                s_d.ien = 1'b1;
            end
            if (cmd_iof) begin
                s_d.ien = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr  = s_q.ar;
    assign mem_wdata = {{(DW-AW){1'b0}}, s_q.tr};
    assign ien       = s_q.ien;
    assign pend      = s_q.pend;

endmodule

// File: rtl/intr_ctl.sv
module intr_ctl #(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int SCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SCW-1:0] sc_step,
    input  logic [AW-1:0]  pc_i,
    output logic           pc_we,
    output logic [AW-1:0]  pc_wdata,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           sc_clr,
    output logic           intr_cycle,
    input  logic           dev_in_stb,
    input  logic [CW-1:0]  dev_in_char,
    input  logic           dev_out_done,
    output logic [CW-1:0]  out_char,
    output logic           out_stb,
    input  logic           cmd_ion,
    input  logic           cmd_iof,
    input  logic           cmd_inp,
    input  logic           cmd_out,
    input  logic           cmd_ski,
    input  logic           cmd_sko,
    input  logic [DW-1:0]  ac_i,
    output logic           ac_lo_we,
    output logic [CW-1:0]  ac_lo_wdata
);

    logic fgi_w;
    logic fgo_w;
    logic ien_w;

    intr_io #(.DW(DW), .CW(CW)) u_io (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_in_stb   (dev_in_stb),
        .dev_in_char  (dev_in_char),
        .dev_out_done (dev_out_done),
        .cmd_inp      (cmd_inp),
        .cmd_out      (cmd_out),
        .ac_i         (ac_i),
        .fgi          (fgi_w),
        .fgo          (fgo_w),
        .ac_lo_we     (ac_lo_we),
        .ac_lo_wdata  (ac_lo_wdata),
        .out_char     (out_char),
        .out_stb      (out_stb)
    );

    intr_seq #(.AW(AW), .DW(DW), .SCW(SCW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_step   (sc_step),
        .pc_i      (pc_i),
        .fgi       (fgi_w),
        .fgo       (fgo_w),
        .cmd_ion   (cmd_ion),
        .cmd_iof   (cmd_iof),
        .cmd_ski   (cmd_ski),
        .cmd_sko   (cmd_sko),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sc_clr    (sc_clr),
        .ien       (ien_w),
        .pend      (intr_cycle)
    );

endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk #(
    parameter int AW  = 12,
    parameter int SCW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [SCW-1:0] sc_step,
    input logic [AW-1:0]  pc_i,
    input logic           pc_we,
    input logic [AW-1:0]  pc_wdata,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           sc_clr,
    input logic           intr_cycle,
    input logic           ien,
    input logic           fgi,
    input logic           fgo,
    input logic           cmd_ski
);

    // R6: the pending flag rises only after enable, a flag and an execute step
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_cycle) |-> $past(ien && (fgi || fgo) && (sc_step > SCW'(2))));

    // R7: enable low blocks the pending flag
    p_no_pend_ien_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_cycle && !ien) |=> !intr_cycle);

    // R8: fetch steps block the pending flag
    p_no_pend_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_cycle && (sc_step <= SCW'(2))) |=> !intr_cycle);

    // R9: only the interrupt cycle writes memory, always at word 0
    p_save_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (intr_cycle && (mem_addr == '0) && (sc_step == SCW'(1))));

    // R9: last step leaves enable and pending cleared
    p_exit_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_cycle && (sc_step == SCW'(2))) |=> (!ien && !intr_cycle));

    // R9: sequence counter clear only at the last interrupt step
    p_sc_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clr |-> (intr_cycle && (sc_step == SCW'(2)) && pc_we && (pc_wdata == pc_i + AW'(1))));

    // R2: no skip on input while the input flag is clear
    p_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ski && !fgi && !fgo && !intr_cycle) |-> !pc_we);

endmodule

bind intr_ctl intr_ctl_chk #(.AW(AW), .SCW(SCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_step    (sc_step),
    .pc_i       (pc_i),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .sc_clr     (sc_clr),
    .intr_cycle (intr_cycle),
    .ien        (ien_w),
    .fgi        (fgi_w),
    .fgo        (fgo_w),
    .cmd_ski    (cmd_ski)
);

// File: tb/intr_ctl_bench.sv
`timescale 1ns/1ps
module intr_ctl_bench;

    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int SCW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [SCW-1:0] sc_step;
    logic [AW-1:0]  pc_i;
    logic           pc_we;
    logic [AW-1:0]  pc_wdata;
    logic           mem_we;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           sc_clr;
    logic           intr_cycle;
    logic           dev_in_stb;
    logic [CW-1:0]  dev_in_char;
    logic           dev_out_done;
    logic [CW-1:0]  out_char;
    logic           out_stb;
    logic           cmd_ion, cmd_iof, cmd_inp, cmd_out, cmd_ski, cmd_sko;
    logic [DW-1:0]  ac_i;
    logic           ac_lo_we;
    logic [CW-1:0]  ac_lo_wdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intr_ctl #(.AW(AW), .DW(DW), .CW(CW), .SCW(SCW)) u_intr_ctl (
        .clk(clk), .rst_n(rst_n), .sc_step(sc_step), .pc_i(pc_i),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sc_clr(sc_clr),
        .intr_cycle(intr_cycle), .dev_in_stb(dev_in_stb),
        .dev_in_char(dev_in_char), .dev_out_done(dev_out_done),
        .out_char(out_char), .out_stb(out_stb), .cmd_ion(cmd_ion),
        .cmd_iof(cmd_iof), .cmd_inp(cmd_inp), .cmd_out(cmd_out),
        .cmd_ski(cmd_ski), .cmd_sko(cmd_sko), .ac_i(ac_i),
        .ac_lo_we(ac_lo_we), .ac_lo_wdata(ac_lo_wdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        dev_in_stb = 0; dev_out_done = 0;
        cmd_ion = 0; cmd_iof = 0; cmd_inp = 0;
        cmd_out = 0; cmd_ski = 0; cmd_sko = 0;
    endtask

    task automatic next();
        @(negedge clk);
        quiet();
    endtask

    task automatic t_reset();
        rst_n = 0; sc_step = '0; pc_i = 12'h100; ac_i = '0; dev_in_char = '0;
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        next();
        #1;
        chk("R1 intr_cycle", int'(intr_cycle), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        chk("R1 out_char", int'(out_char), 0);
        chk("R1 out_stb", int'(out_stb), 0);
        chk("R1 pc_we", int'(pc_we), 0);
        cmd_ski = 1; cmd_sko = 1; #1;
        chk("R1 flags clear, no skip", int'(pc_we), 0);
    endtask

    task automatic t_input_skip();
        next();
        cmd_ski = 1; #1;
        chk("R2 ski with flag 0", int'(pc_we), 0);
        next();
        dev_in_stb = 1; dev_in_char = 8'hA5;
        next();
        cmd_ski = 1; pc_i = 12'h100; #1;
        chk("R2 ski pc_we", int'(pc_we), 1);
        chk("R2 ski pc_wdata", int'(pc_wdata), 12'h101);
    endtask

    task automatic t_inp();
        next();
        cmd_inp = 1; #1;
        chk("R3 ac_lo_we", int'(ac_lo_we), 1);
        chk("R3 ac_lo_wdata", int'(ac_lo_wdata), 8'hA5);
        next();
        cmd_ski = 1; #1;
        chk("R3 input flag cleared", int'(pc_we), 0);
    endtask

    task automatic t_out();
        next();
        dev_out_done = 1;
        next();
        cmd_sko = 1; pc_i = 12'h2FF; #1;
        chk("R4 sko pc_we", int'(pc_we), 1);
        chk("R4 sko pc_wdata", int'(pc_wdata), 12'h300);
        next();
        cmd_out = 1; ac_i = 16'h1C3;
        next();
        #1;
        chk("R4 out_char", int'(out_char), 8'hC3);
        chk("R4 out_stb pulse", int'(out_stb), 1);
        cmd_sko = 1; #1;
        chk("R4 output flag cleared", int'(pc_we), 0);
        next();
        #1;
        chk("R4 out_stb one cycle", int'(out_stb), 0);
        // R11: OUT and device done together
        next();
        dev_out_done = 1;
        next();
        dev_out_done = 1; cmd_out = 1; ac_i = 16'h0042;
        next();
        cmd_sko = 1; #1;
        chk("R11 out beats done", int'(pc_we), 0);
        chk("R11 out_char", int'(out_char), 8'h42);
    endtask

    task automatic t_collide();
        next();
        dev_in_stb = 1; dev_in_char = 8'h11;
        next();
        cmd_inp = 1; dev_in_stb = 1; dev_in_char = 8'h22; #1;
        chk("R5 old char to acc", int'(ac_lo_wdata), 8'h11);
        next();
        cmd_ski = 1; #1;
        chk("R5 flag stays set", int'(pc_we), 1);
        next();
        cmd_inp = 1; #1;
        chk("R5 new char held", int'(ac_lo_wdata), 8'h22);
        next();
        cmd_ski = 1; #1;
        chk("R5 flag cleared after second take", int'(pc_we), 0);
    endtask

    task automatic t_ien_off();
        next();
        dev_in_stb = 1; dev_in_char = 8'h33;
        next();
        sc_step = 4'd3;
        next();
        sc_step = 4'd5;
        next();
        sc_step = '0; #1;
        chk("R7 no pending with enable 0", int'(intr_cycle), 0);
    endtask

    task automatic t_fetch_block();
        next();
        cmd_ion = 1; sc_step = 4'd3;
        next();
        #1;
        chk("R10 enable counts next cycle", int'(intr_cycle), 0);
        for (int s = 0; s < 3; s++) begin
            sc_step = SCW'(s);
            next();
            #1;
            chk("R8 fetch step blocks pending", int'(intr_cycle), 0);
        end
    endtask

    task automatic run_irq(input logic [AW-1:0] pc_at, input bit verbose);
        sc_step = 4'd4;
        next();
        #1;
        if (verbose) chk("R6 pending set", int'(intr_cycle), 1);
        sc_step = 4'd0; pc_i = pc_at; #1;
        if (verbose) begin
            chk("R9 step0 no write", int'(mem_we), 0);
            chk("R9 step0 no pc load", int'(pc_we), 0);
        end
        next();
        sc_step = 4'd1; pc_i = pc_at + 12'd1; #1;
        if (verbose) begin
            chk("R9 step1 mem_we", int'(mem_we), 1);
            chk("R9 step1 mem_addr", int'(mem_addr), 0);
            chk("R9 step1 mem_wdata", int'(mem_wdata), int'(pc_at));
            chk("R9 step1 pc cleared", int'(pc_wdata), 0);
        end
        next();
        sc_step = 4'd2; pc_i = '0; #1;
        if (verbose) begin
            chk("R9 step2 pc_we", int'(pc_we), 1);
            chk("R9 step2 vector", int'(pc_wdata), 1);
            chk("R9 step2 sc_clr", int'(sc_clr), 1);
        end
        next();
        sc_step = 4'd3;
        next();
        sc_step = '0; #1;
        if (verbose) chk("R9 enable cleared, no re-entry", int'(intr_cycle), 0);
    endtask

    task automatic t_interrupt();
        run_irq(12'h2A7, 1'b1);
    endtask

    task automatic t_ion_iof();
        next();
        cmd_ion = 1;
        next();
        cmd_ion = 1; cmd_iof = 1;
        next();
        sc_step = 4'd3;
        next();
        sc_step = '0; #1;
        chk("R10 iof wins over ion", int'(intr_cycle), 0);
        next();
        cmd_ion = 1;
        next();
        sc_step = 4'd3;
        next();
        sc_step = '0; #1;
        chk("R10 ion enables", int'(intr_cycle), 1);
        sc_step = 4'd1;
        next();
        sc_step = 4'd2;
        next();
        sc_step = '0;
    endtask

    initial begin
        t_reset();
        t_input_skip();
        t_inp();
        t_out();
        t_collide();
        t_ien_off();
        t_fetch_block();
        t_interrupt();
        t_ion_iof();
        next();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule